// File: doc/BRIEF.md
# Configuration Start-Up Sequencer

This block steps a configurable device through its start-up handshake. A start event comes from the power-on reset being released or from a falling edge on the active-low program request. On that event the sequencer clears configuration memory and pulls the shared INITN line low. It then waits for that line to read high, because another device may be holding it down. Next it runs the configuration phase, releases the shared DONE line once the done bit is written, and waits for DONE to read high before it reports wake-up.

The configuration mode is captured at the start event. In a master mode the sequencer enables the configuration clock and turns it to output. The clock keeps running for a fixed number of extra cycles after wake-up, so that later devices in a daisy chain can finish their own wake-up, and then it turns back to input. In SPI modes the flash chip-select is pulled low only while configuration data is being read.

Both shared lines are open drain. Each is modelled as a pull-low enable output plus a sampled input level, and the block never drives either line high. The bitstream loader, the oscillator and the memory array are outside the block and appear only as handshake signals.

Top module: `cfg_sequencer`

## Requirements
- R1: After synchronous reset, with `por_done` low, no start event has happened: both pull-low enables, `mem_clear`, `cfg_active`, `wake_done`, `mclk_en` and `mclk_dir_out` are 0 and `spi_cs_n` is 1.
- R2: A start event is a 0-to-1 change of `por_done`, or a 1-to-0 change of `prog_n` while `jtag_active` is 0. It can happen in any phase. One cycle after the event, `mem_clear` and `initn_pull_low` are 1.
- R3: While `jtag_active` is 1, falling edges and low levels on `prog_n` start nothing and stretch nothing. The outputs keep their values.
- R4: `mode_sel` is captured only at a start event. The modes 3'b001, 3'b010 and 3'b011 are master modes: from the first clear cycle to the end of the extra clocks, `mclk_en` and `mclk_dir_out` are 1. For any other mode they stay 0. Changing `mode_sel` after the start event has no effect.
- R5: The memory-clear phase (`mem_clear` and `initn_pull_low` both 1) lasts exactly CLEAR_CYCLES cycles. If `prog_n` is held low (with `jtag_active` at 0) for H cycles from the start event, the phase lasts max(CLEAR_CYCLES, H) cycles.
- R6: After the clear phase `initn_pull_low` drops to 0. While `initn_in` reads low, configuration does not begin, even if `done_bit` is 1. `cfg_active` stays 1, DONE stays pulled low and `spi_cs_n` stays 1.
- R7: In the configuration phase, `cfg_error` at 1 pulls INITN low in the same cycle. The error is latched: INITN and DONE stay pulled low and wake-up never comes until the next start event.
- R8: `done_pull_low` is 1 from the start event through the configuration phase. It drops to 0 only in the cycle after `done_bit`, `initn_in` and `prog_n` are all high together in that phase.
- R9: After DONE is released, `wake_done` stays 0 while `done_in` reads low. It becomes 1 one cycle after `done_in` reads high.
- R10: In a master mode, `mclk_en` stays 1 for exactly EXTRA_CYCLES cycles counted from the first cycle `wake_done` is 1. Then `mclk_en` and `mclk_dir_out` fall to 0, while `wake_done` stays 1 and `cfg_active` is 0.
- R11: A start event after wake-up drops `wake_done` and, in a master mode, turns the configuration clock back on in the next cycle.
- R12: `spi_cs_n` is 0 only in the configuration phase of an SPI mode (3'b010 or 3'b011) without a latched error. It is 1 in every other phase and in every other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| por_done | input | 1 | Power-on reset released (level, rising edge starts) |
| prog_n | input | 1 | Active-low program request |
| jtag_active | input | 1 | Boundary-scan access active; program request is ignored |
| mode_sel | input | 3 | Configuration mode select, captured at start |
| cfg_error | input | 1 | Configuration error reported by the loader |
| done_bit | input | 1 | Done bit has been written by the loader |
| initn_in | input | 1 | Sampled level of the shared INITN line |
| done_in | input | 1 | Sampled level of the shared DONE line |
| initn_pull_low | output | 1 | Pull INITN line low |
| done_pull_low | output | 1 | Pull DONE line low |
| mem_clear | output | 1 | Clear configuration memory |
| cfg_active | output | 1 | Start-up in progress (clear, wait, configure, wake) |
| wake_done | output | 1 | Wake-up complete |
| mclk_en | output | 1 | Enable configuration clock oscillator |
| mclk_dir_out | output | 1 | Configuration clock pin is output (1) or input (0) |
| spi_cs_n | output | 1 | SPI flash chip-select, active low |

## Verification
The bench models both open-drain lines, so that either line reads low when the block or the bench pulls it. It runs the full sequence in all eight modes, which separates master from slave clock behaviour and SPI from non-SPI chip-select behaviour, and it scrambles the mode inputs after each start to show that capture happens only at the start event. It sweeps the program-request low time from 1 to 8 cycles across the fixed clear length, to check both the minimum and the stretched clear phase. Further runs hold INITN and DONE low from outside to check the stalls, inject an error during configuration, and toggle the program request while boundary-scan access is active.

// File: rtl/cfg_seq_pkg.sv
// Shared types for the configuration start-up sequencer.
// Holds the phase encoding and the decode of the captured mode value.
package cfg_seq_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT_CLEAR,
        ST_INIT_WAIT,
        ST_CONFIG,
        ST_WAKEUP,
        ST_EXTRA_CLK,
        ST_USER
    } seq_state_e;

    typedef struct packed {
        logic master;   // block sources the configuration clock
        logic spi;      // configuration data comes from SPI flash
    } mode_attr_t;

    // Map a mode value to its clock-source and data-port attributes.
    function automatic mode_attr_t decode_mode(input logic [MODE_W-1:0] m);
        mode_attr_t a;
        a.spi    = (m == 3'b010) || (m == 3'b011);
        a.master = (m == 3'b001) || a.spi;
        return a;
    endfunction

endpackage

// File: rtl/cfg_start_detect.sv
// Start-event detector.
// Turns a rising power-on-release level or a falling program request into a
// one-cycle start pulse. The program request is masked while boundary-scan
// access is active. Assumes both inputs are already synchronous to clk.
module cfg_start_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic por_done,
    input  logic prog_n,
    input  logic jtag_active,
    output logic start,
    output logic prog_hold
);

    logic por_q;
    logic prog_q;

    // Keep last-cycle copies of both request inputs for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            por_q  <= 1'b0;
            prog_q <= 1'b1;
        end else begin
            por_q  <= por_done;
            prog_q <= prog_n;
        end
    end

    // Form the start pulse and the stretch request for the clear phase.
    always_comb begin
        start     = (por_done && !por_q) || (!prog_n && prog_q && !jtag_active);
        prog_hold = !prog_n && !jtag_active;
    end

    // R3: a masked program request never produces a start on its own
    p_jtag_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (jtag_active && !(por_done && !por_q)) |-> !start);

endmodule

// File: rtl/cfg_phase_timer.sv
// Saturating phase timer.
// Counts cycles spent in a timed phase and flags the last one. It restarts
// from zero while clr is high. Assumes target is at least 1.
module cfg_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] target,
    output logic             hit
);

    logic [CNT_W-1:0] cnt_q;

    // Flag the final cycle of the phase.
    always_comb hit = (cnt_q == target - 1'b1);

    // Count up while running, stop at the final value, restart on clr.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (!hit) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R5/R10: the count never runs past the phase length
    p_cnt_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < target || clr);

endmodule

// File: rtl/cfg_seq_fsm.sv
// Start-up phase controller.
// Walks through clear, INITN wait, configuration, DONE wait, extra clocks and
// user mode. It captures the mode at each start and latches configuration
// errors. Assumes the line levels are already synchronous to clk.
module cfg_seq_fsm
    import cfg_seq_pkg::*;
#(
    parameter int CNT_W        = 8,
    parameter int CLEAR_CYCLES = 4,
    parameter int EXTRA_CYCLES = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              prog_hold,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              cfg_error,
    input  logic              done_bit,
    input  logic              initn_in,
    input  logic              done_in,
    input  logic              timer_hit,
    output seq_state_e        state_q,
    output logic              err_q,
    output mode_attr_t        attr_q,
    output logic              timer_clr,
    output logic [CNT_W-1:0]  timer_target
);

    seq_state_e state_d;
    logic       err_d;

    // Choose the next phase from the current phase and the handshake inputs.
    always_comb begin
        state_d = state_q;
        err_d   = err_q;
        if (start) begin
            state_d = ST_INIT_CLEAR;
            err_d   = 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE:       state_d = ST_IDLE;
                ST_INIT_CLEAR: if (timer_hit && !prog_hold) state_d = ST_INIT_WAIT;
                ST_INIT_WAIT:  if (initn_in) state_d = ST_CONFIG;
                ST_CONFIG: begin
                    if (err_q || cfg_error) begin
                        err_d = 1'b1;
                    end else if (done_bit && initn_in && !prog_hold) begin
                        state_d = ST_WAKEUP;
                    end
                end
                ST_WAKEUP:     if (done_in) state_d = attr_q.master ? ST_EXTRA_CLK : ST_USER;
                ST_EXTRA_CLK:  if (timer_hit) state_d = ST_USER;
                ST_USER:       state_d = ST_USER;
                default:       state_d = ST_IDLE;
            endcase
        end
    end

    // Register the phase, the error latch and the captured mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b0;
            attr_q  <= '0;
        end else begin
            state_q <= state_d;
            err_q   <= err_d;
            if (start) attr_q <= decode_mode(mode_sel);
        end
    end

    // Restart the timer outside timed phases and on every start event.
    always_comb begin
        timer_clr    = start || !((state_q == ST_INIT_CLEAR) || (state_q == ST_EXTRA_CLK));
        timer_target = (state_q == ST_EXTRA_CLK) ? CNT_W'(EXTRA_CYCLES) : CNT_W'(CLEAR_CYCLES);
    end

    // R5: a held program request keeps the clear phase running
    p_clear_stretch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INIT_CLEAR && prog_hold && !start) |=> state_q == ST_INIT_CLEAR);

    // R6: a low INITN line blocks entry to configuration
    p_initn_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INIT_WAIT && !initn_in && !start) |=> state_q == ST_INIT_WAIT);

    // R7: a latched error holds the block in configuration
    p_err_latched_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONFIG && err_q && !start) |=> (state_q == ST_CONFIG && err_q));

    // R9: a low DONE line blocks wake-up
    p_done_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAKEUP && !done_in && !start) |=> state_q == ST_WAKEUP);

endmodule

// File: rtl/cfg_sequencer.sv
// Configuration start-up sequencer, top level.
// Connects start detection, the phase controller and the phase timer, and
// decodes the line, clock and chip-select controls from the phase. Shared
// lines are open drain: the block only ever pulls them low.
module cfg_sequencer
    import cfg_seq_pkg::*;
#(
    parameter int CLEAR_CYCLES = 4,
    parameter int EXTRA_CYCLES = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_done,
    input  logic              prog_n,
    input  logic              jtag_active,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              cfg_error,
    input  logic              done_bit,
    input  logic              initn_in,
    input  logic              done_in,
    output logic              initn_pull_low,
    output logic              done_pull_low,
    output logic              mem_clear,
    output logic              cfg_active,
    output logic              wake_done,
    output logic              mclk_en,
    output logic              mclk_dir_out,
    output logic              spi_cs_n
);

    localparam int CNT_MAX = (CLEAR_CYCLES > EXTRA_CYCLES) ? CLEAR_CYCLES : EXTRA_CYCLES;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    if (EXTRA_CYCLES < 100 || EXTRA_CYCLES > 500) begin : g_bad_extra
        $error("EXTRA_CYCLES must lie in 100..500");
    end
    if (CLEAR_CYCLES < 1) begin : g_bad_clear
        $error("CLEAR_CYCLES must be at least 1");
    end

    logic             start;
    logic             prog_hold;
    logic             timer_hit;
    logic             timer_clr;
    logic [CNT_W-1:0] timer_target;
    seq_state_e       state_q;
    logic             err_q;
    mode_attr_t       attr_q;

    cfg_start_detect u_start (
        .clk         (clk),
        .rst_n       (rst_n),
        .por_done    (por_done),
        .prog_n      (prog_n),
        .jtag_active (jtag_active),
        .start       (start),
        .prog_hold   (prog_hold)
    );

    cfg_seq_fsm #(
        .CNT_W        (CNT_W),
        .CLEAR_CYCLES (CLEAR_CYCLES),
        .EXTRA_CYCLES (EXTRA_CYCLES)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .prog_hold    (prog_hold),
        .mode_sel     (mode_sel),
        .cfg_error    (cfg_error),
        .done_bit     (done_bit),
        .initn_in     (initn_in),
        .done_in      (done_in),
        .timer_hit    (timer_hit),
        .state_q      (state_q),
        .err_q        (err_q),
        .attr_q       (attr_q),
        .timer_clr    (timer_clr),
        .timer_target (timer_target)
    );

    cfg_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (timer_clr),
        .target (timer_target),
        .hit    (timer_hit)
    );

    // Decode the external controls from the phase and the captured mode.
    always_comb begin
        logic clk_run;
        clk_run        = attr_q.master && (state_q != ST_IDLE) && (state_q != ST_USER);
        mem_clear      = (state_q == ST_INIT_CLEAR);
        initn_pull_low = (state_q == ST_INIT_CLEAR) ||
                         ((state_q == ST_CONFIG) && (err_q || cfg_error));
        done_pull_low  = (state_q == ST_INIT_CLEAR) || (state_q == ST_INIT_WAIT) ||
                         (state_q == ST_CONFIG);
        cfg_active     = (state_q == ST_INIT_CLEAR) || (state_q == ST_INIT_WAIT) ||
                         (state_q == ST_CONFIG) || (state_q == ST_WAKEUP);
        wake_done      = (state_q == ST_EXTRA_CLK) || (state_q == ST_USER);
        mclk_en        = clk_run;
        mclk_dir_out   = clk_run;
        spi_cs_n       = !((state_q == ST_CONFIG) && attr_q.spi && !err_q);
    end

    logic past_valid_q;

    // Mark cycles whose previous sample was taken out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_valid_q <= 1'b0;
        else        past_valid_q <= 1'b1;
    end

    // R8: DONE is only let go after INITN, program request and done bit agree
    p_done_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid_q && $fell(done_pull_low)) |->
            $past(done_bit && initn_in && (prog_n || jtag_active)));

    // R12: chip-select is high outside active start-up
    p_cs_idle_high_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_active |-> spi_cs_n);

    // R9: wake-up is never reported while this block still pulls DONE low
    p_wake_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_done |-> !done_pull_low);

endmodule

// File: tb/cfg_sequencer_tb.sv
// Self-checking bench for the configuration start-up sequencer.
module cfg_sequencer_tb;

    localparam int CLR = 4;
    localparam int EXT = 100;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       por_done, prog_n, jtag_active, cfg_error, done_bit;
    logic [2:0] mode_sel;
    logic       hold_initn, hold_done;
    logic       initn_in, done_in;
    logic       initn_pull_low, done_pull_low, mem_clear, cfg_active;
    logic       wake_done, mclk_en, mclk_dir_out, spi_cs_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    always #4 clk = ~clk;

    // Open-drain lines: low if either side pulls.
    assign initn_in = ~(initn_pull_low | hold_initn);
    assign done_in  = ~(done_pull_low | hold_done);

    cfg_sequencer #(
        .CLEAR_CYCLES (CLR),
        .EXTRA_CYCLES (EXT)
    ) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .por_done       (por_done),
        .prog_n         (prog_n),
        .jtag_active    (jtag_active),
        .mode_sel       (mode_sel),
        .cfg_error      (cfg_error),
        .done_bit       (done_bit),
        .initn_in       (initn_in),
        .done_in        (done_in),
        .initn_pull_low (initn_pull_low),
        .done_pull_low  (done_pull_low),
        .mem_clear      (mem_clear),
        .cfg_active     (cfg_active),
        .wake_done      (wake_done),
        .mclk_en        (mclk_en),
        .mclk_dir_out   (mclk_dir_out),
        .spi_cs_n       (spi_cs_n)
    );

    function automatic bit is_master(logic [2:0] m);
        return (m == 3'b001) || (m == 3'b010) || (m == 3'b011);
    endfunction

    function automatic bit is_spi(logic [2:0] m);
        return (m == 3'b010) || (m == 3'b011);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // One full start-up: start, clear, INITN wait, configure, wake, extra clocks.
    task automatic run_cfg(input bit use_por, input int hold_prog, input logic [2:0] mode,
                           input int initn_wait, input bit inject_err);
        bit exp_m = is_master(mode);
        bit exp_s = is_spi(mode);
        int cnt   = 0;
        int exp_len;
        mode_sel   = mode;
        done_bit   = 1'b0;
        hold_initn = (initn_wait > 0);
        if (use_por) por_done = 1'b1;
        else         prog_n   = 1'b0;
        for (int i = 1; i <= 64; i++) begin
            @(negedge clk);
            if (!use_por && i == hold_prog) prog_n = 1'b1;
            if (i == 1) begin
                chk("R2 mem_clear", mem_clear, 1);
                chk("R2 initn_pull_low", initn_pull_low, 1);
                chk("R11 wake_done", wake_done, 0);
                chk("R4 mclk_en", mclk_en, exp_m);
                chk("R4 mclk_dir_out", mclk_dir_out, exp_m);
                mode_sel = ~mode;
            end
            if (!mem_clear) break;
            cnt++;
            chk("R8 done_pull_low in clear", done_pull_low, 1);
        end
        exp_len = (use_por || hold_prog < CLR) ? CLR : hold_prog;
        chk("R5 clear length", cnt, exp_len);
        chk("R6 initn released", initn_pull_low, 0);
        done_bit = 1'b1;
        for (int i = 0; i < initn_wait; i++) begin
            chk("R6 cs held", spi_cs_n, 1);
            chk("R6 done held low", done_pull_low, 1);
            chk("R6 still active", cfg_active, 1);
            @(negedge clk);
        end
        hold_initn = 1'b0;
        done_bit   = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            chk("R12 cs in config", spi_cs_n, !exp_s);
            chk("R8 done low in config", done_pull_low, 1);
            chk("R4 mode kept", mclk_en, exp_m);
            @(negedge clk);
        end
        if (inject_err) begin
            cfg_error = 1'b1;
            #1;
            chk("R7 initn on error", initn_pull_low, 1);
            @(negedge clk);
            cfg_error = 1'b0;
            done_bit  = 1'b1;
            for (int i = 0; i < 4; i++) begin
                chk("R7 initn latched", initn_pull_low, 1);
                chk("R7 done held", done_pull_low, 1);
                chk("R7 no wake", wake_done, 0);
                chk("R12 cs after error", spi_cs_n, 1);
                @(negedge clk);
            end
            return;
        end
        done_bit  = 1'b1;
        hold_done = 1'b1;
        @(negedge clk);
        chk("R8 done released", done_pull_low, 0);
        chk("R12 cs after config", spi_cs_n, 1);
        for (int i = 0; i < 3; i++) begin
            chk("R9 wake stalled", wake_done, 0);
            @(negedge clk);
        end
        hold_done = 1'b0;
        @(negedge clk);
        chk("R9 wake", wake_done, 1);
        cnt = 0;
        while (mclk_en && cnt < 1000) begin
            cnt++;
            @(negedge clk);
        end
        chk("R10 extra clocks", cnt, exp_m ? EXT : 0);
        chk("R10 dir input", mclk_dir_out, 0);
        chk("R10 wake kept", wake_done, 1);
        chk("R10 inactive", cfg_active, 0);
        chk("R12 cs in user", spi_cs_n, 1);
    endtask

    initial begin
        rst_n = 1'b0; por_done = 1'b0; prog_n = 1'b1; jtag_active = 1'b0;
        mode_sel = 3'b000; cfg_error = 1'b0; done_bit = 1'b0;
        hold_initn = 1'b0; hold_done = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 initn", initn_pull_low, 0);
        chk("R1 done", done_pull_low, 0);
        chk("R1 clear", mem_clear, 0);
        chk("R1 active", cfg_active, 0);
        chk("R1 wake", wake_done, 0);
        chk("R1 mclk", mclk_en, 0);
        chk("R1 dir", mclk_dir_out, 0);
        chk("R1 cs", spi_cs_n, 1);

        // R3: program request masked in idle
        jtag_active = 1'b1;
        prog_n      = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R3 no clear", mem_clear, 0);
            chk("R3 no initn", initn_pull_low, 0);
        end
        prog_n = 1'b1;
        @(negedge clk);
        jtag_active = 1'b0;
        @(negedge clk);
        chk("R3 still idle", mem_clear, 0);

        run_cfg(1'b1, 0, 3'b001, 0, 1'b0);
        for (int m = 0; m < 8; m++) run_cfg(1'b0, 1, 3'(m), m % 3, 1'b0);
        for (int h = 1; h <= 8; h++) run_cfg(1'b0, h, 3'b000, 0, 1'b0);
        run_cfg(1'b0, 1, 3'b010, 2, 1'b1);
        run_cfg(1'b0, 2, 3'b011, 0, 1'b0);

        // R3: program request masked after wake-up
        jtag_active = 1'b1;
        prog_n      = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R3 user kept", wake_done, 1);
            chk("R3 no clear in user", mem_clear, 0);
        end
        prog_n = 1'b1;
        @(negedge clk);
        jtag_active = 1'b0;
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

endmodule